// File: doc/BRIEF.md
# Linked-Table Address Translator

This block sits between a trace-buffer write master and system memory. It maps a flat input window onto 4 KB physical pages that may lie anywhere. The mapping lives in page tables held in memory. Each table page is 4 KB and holds 64-bit entries. The first 256 entries are data-page pointers, so one table covers 1 MB of input space. Two fixed slots near the end of each table hold links to the previous table and to the next one.

The unit keeps one table as its current table, recording that table's address and its number in the chain. A request that falls in the current 1 MB region costs one entry read. A request that falls in another region walks the chain one link at a time until it reaches the right table, and that table then becomes the current one.

In pass-through mode, addresses go out unchanged and no memory is read. Software sets up the unit through a small register port while the unit is disabled, and then enables it.

Top module: `pgchain_xlate`

## Requirements
- R1: With mode bit 0 clear (pass-through), each accepted request returns `resp_addr` equal to `req_addr` with `resp_err` low on the cycle after acceptance. No table read is issued. The input base and table base have no effect, so an address below the input base also passes.
- R2: With mode bit 0 set (translate), the offset is `req_addr` minus the input base. The table number is offset bits above 20, and the entry index is offset bits 19:12. The entry is read from byte address table page + 8*index. The result is entry bits AW-1:12 followed by `req_addr` bits 11:0.
- R3: If the data entry read has bit 0 clear, the response carries `resp_err` high and `resp_addr` zero.
- R4: If the target table number is above the current one, the unit reads entry slot 511 (byte 0xFF8) of the current table. If it is below, the unit reads slot 510 (byte 0xFF0). Each valid link moves the current table by exactly one. Every table read falls inside the current table page.
- R5: A link with bit 0 clear ends the walk with an error response. The current table stays at the last table the walk reached.
- R6: In translate mode, an address below the input base gives an error response on the next cycle. No memory read is issued.
- R7: Setting the enable bit (register 0, bit 0) loads the table base as the current table, with table number 0.
- R8: While enable is set, writes to mode (register 1), table base (register 3) and input base (register 4) are ignored.
- R9: Input base bits 19:0 and table base bits 11:0 are always zero, whatever value is written.
- R10: Status (register 2, read-only) bit 0 reads 1 exactly when enable is clear and no walk is in progress.
- R11: `req_ready` is high only when the unit is enabled and idle. At most one table read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr | input | 3 | Register index (0 control, 1 mode, 2 status, 3 table base, 4 input base) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| req_valid | input | 1 | Input address request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | AW | Input address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_addr | output | AW | Output (translated or passed) address |
| resp_err | output | 1 | Lookup failed |
| mem_req | output | 1 | Table entry read request pulse |
| mem_addr | output | AW | Byte address of the table entry |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 64 | Table entry read data |

## Verification
The assertions assume a well-behaved memory port: it returns exactly one `mem_rvalid` for each `mem_req`, and it never sends read data when no read is pending. They also assume that a requester holds `req_valid` and `req_addr` steady until acceptance. The bench memory model answers every read exactly once after a fixed two-cycle latency and stays silent otherwise. The bench keeps each request asserted until `req_ready` is seen. Random offsets stay within five 1 MB regions of a four-table chain, so walks remain short while still reaching the invalid end links.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int PAGE_SHIFT   = 12;
  localparam int REGION_SHIFT = 20;
  localparam int IDX_W        = REGION_SHIFT - PAGE_SHIFT;
  localparam int ENT_SHIFT    = 3;
  localparam int SLOT_W       = PAGE_SHIFT - ENT_SHIFT;

  localparam logic [SLOT_W-1:0] SLOT_PREV = SLOT_W'(510);
  localparam logic [SLOT_W-1:0] SLOT_NEXT = SLOT_W'(511);

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_MODE  = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_TBASE = 3'd3;
  localparam logic [2:0] RA_IBASE = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_WAIT} walk_st_e;
  typedef enum logic [1:0] {FK_DATA, FK_NEXT, FK_PREV} fetch_e;
endpackage

// File: rtl/pcx_regs.sv
module pcx_regs
  import pcx_pkg::*;
#(
  parameter int AW = 40,
  localparam int PADW = 64 - AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  input  logic          walker_idle,
  output logic          en,
  output logic          xlate,
  output logic          en_load,
  output logic [AW-1:0] tbase,
  output logic [AW-1:0] ibase
);
  logic          en_q, xlate_q;
  logic [AW-1:0] tbase_q, ibase_q;
  logic          ready;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign ready   = !en_q && walker_idle;
  assign en_load = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0] && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      xlate_q   <= 1'b0;
      tbase_q   <= '0;
      ibase_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          RA_CTRL: begin
            if (en_load) en_q <= 1'b1;
            else if (!reg_wdata[0]) en_q <= 1'b0;
          end
          RA_MODE:  if (!en_q) xlate_q <= reg_wdata[0];
          RA_TBASE: if (!en_q) tbase_q <= {reg_wdata[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
          RA_IBASE: if (!en_q) ibase_q <= {reg_wdata[AW-1:REGION_SHIFT], {REGION_SHIFT{1'b0}}};
          default: ;
        endcase
      end
      if (reg_rd) begin
        unique case (reg_addr)
          RA_CTRL:  reg_rdata <= {63'd0, en_q};
          RA_MODE:  reg_rdata <= {63'd0, xlate_q};
          RA_STAT:  reg_rdata <= {63'd0, ready};
          RA_TBASE: reg_rdata <= {{PADW{1'b0}}, tbase_q};
          RA_IBASE: reg_rdata <= {{PADW{1'b0}}, ibase_q};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assign en    = en_q;
  assign xlate = xlate_q;
  assign tbase = tbase_q;
  assign ibase = ibase_q;

  // R8: configuration is frozen while the unit stays enabled
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q)) |-> ($stable(xlate_q) && $stable(tbase_q) && $stable(ibase_q)));

  // R9: alignment of the base registers
  p_base_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    (tbase_q[PAGE_SHIFT-1:0] == '0) && (ibase_q[REGION_SHIFT-1:0] == '0));
endmodule

// File: rtl/pcx_offset_dec.sv
module pcx_offset_dec
  import pcx_pkg::*;
#(
  parameter int AW = 40,
  localparam int TNW = AW - REGION_SHIFT
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    ibase,
  output logic             below,
  output logic [TNW-1:0]   tnum,
  output logic [IDX_W-1:0] idx
);
  logic [AW-1:0] off;
  logic          unused_off;

  assign off        = addr - ibase;
  assign below      = addr < ibase;
  assign tnum       = off[AW-1:REGION_SHIFT];
  assign idx        = off[REGION_SHIFT-1:PAGE_SHIFT];
  assign unused_off = ^off[PAGE_SHIFT-1:0];
endmodule

// File: rtl/pcx_walker.sv
module pcx_walker
  import pcx_pkg::*;
#(
  parameter int AW = 40,
  localparam int TNW = AW - REGION_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             xlate,
  input  logic             en_load,
  input  logic [AW-1:0]    tbase,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             dec_below,
  input  logic [TNW-1:0]   dec_tnum,
  input  logic [IDX_W-1:0] dec_idx,
  output logic             resp_valid,
  output logic [AW-1:0]    resp_addr,
  output logic             resp_err,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             idle
);
  walk_st_e               state_q;
  fetch_e                 kind_q;
  logic [AW-1:0]          cur_addr;
  logic [TNW-1:0]         cur_num;
  logic [TNW-1:0]         pend_tnum;
  logic [IDX_W-1:0]       pend_idx;
  logic [PAGE_SHIFT-1:0]  pend_lo;
  logic                   acc;
  logic                   unused_rdata;

  assign unused_rdata = ^{mem_rdata[63:AW], mem_rdata[PAGE_SHIFT-1:1]};
  assign idle      = (state_q == ST_IDLE);
  assign req_ready = en && idle;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      kind_q     <= FK_DATA;
      cur_addr   <= '0;
      cur_num    <= '0;
      pend_tnum  <= '0;
      pend_idx   <= '0;
      pend_lo    <= '0;
      resp_valid <= 1'b0;
      resp_addr  <= '0;
      resp_err   <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_req    <= 1'b0;
      if (en_load) begin
        cur_addr <= tbase;
        cur_num  <= '0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            pend_tnum <= dec_tnum;
            pend_idx  <= dec_idx;
            pend_lo   <= req_addr[PAGE_SHIFT-1:0];
            if (!xlate) begin
              resp_valid <= 1'b1;
              resp_addr  <= req_addr;
              resp_err   <= 1'b0;
            end else if (dec_below) begin
              resp_valid <= 1'b1;
              resp_addr  <= '0;
              resp_err   <= 1'b1;
            end else begin
              state_q <= ST_STEP;
            end
          end
        end
        ST_STEP: begin
          mem_req <= 1'b1;
          state_q <= ST_WAIT;
          if (pend_tnum == cur_num) begin
            kind_q   <= FK_DATA;
            mem_addr <= {cur_addr[AW-1:PAGE_SHIFT], 1'b0, pend_idx, {ENT_SHIFT{1'b0}}};
          end else if (pend_tnum > cur_num) begin
            kind_q   <= FK_NEXT;
            mem_addr <= {cur_addr[AW-1:PAGE_SHIFT], SLOT_NEXT, {ENT_SHIFT{1'b0}}};
          end else begin
            kind_q   <= FK_PREV;
            mem_addr <= {cur_addr[AW-1:PAGE_SHIFT], SLOT_PREV, {ENT_SHIFT{1'b0}}};
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            if (kind_q == FK_DATA) begin
              resp_valid <= 1'b1;
              state_q    <= ST_IDLE;
              if (mem_rdata[0]) begin
                resp_addr <= {mem_rdata[AW-1:PAGE_SHIFT], pend_lo};
                resp_err  <= 1'b0;
              end else begin
                resp_addr <= '0;
                resp_err  <= 1'b1;
              end
            end else if (mem_rdata[0]) begin
              cur_addr <= {mem_rdata[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
              cur_num  <= (kind_q == FK_NEXT) ? cur_num + TNW'(1) : cur_num - TNW'(1);
              state_q  <= ST_STEP;
            end else begin
              resp_valid <= 1'b1;
              resp_addr  <= '0;
              resp_err   <= 1'b1;
              state_q    <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: requests only enter an enabled unit
  p_accept_enabled_r11: assert property (@(posedge clk) disable iff (rst)
    acc |-> en);

  // R11: one outstanding table read
  p_one_read_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R4: every table read stays within the current table page
  p_read_in_table_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[AW-1:PAGE_SHIFT] == cur_addr[AW-1:PAGE_SHIFT]));

  // R4: a valid next link advances the table number by one
  p_next_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && mem_rvalid && kind_q == FK_NEXT && mem_rdata[0])
      |=> (cur_num == $past(cur_num) + TNW'(1)));

  // R1: pass-through answers on the next cycle with the same address
  p_pass_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && !xlate) |=> (resp_valid && !resp_err && resp_addr == $past(req_addr)));

  // R6: below-base address errors at once, no read
  p_below_err_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && xlate && dec_below) |=> (resp_valid && resp_err && !mem_req));
endmodule

// File: rtl/pgchain_xlate.sv
module pgchain_xlate
  import pcx_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          resp_valid,
  output logic [AW-1:0] resp_addr,
  output logic          resp_err,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata
);
  localparam int TNW = AW - REGION_SHIFT;

  logic             en, xlate, en_load, walker_idle;
  logic [AW-1:0]    tbase, ibase;
  logic             dec_below;
  logic [TNW-1:0]   dec_tnum;
  logic [IDX_W-1:0] dec_idx;

  pcx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .walker_idle(walker_idle),
    .en(en), .xlate(xlate), .en_load(en_load), .tbase(tbase), .ibase(ibase)
  );

  pcx_offset_dec #(.AW(AW)) u_dec (
    .addr(req_addr), .ibase(ibase), .below(dec_below), .tnum(dec_tnum), .idx(dec_idx)
  );

  pcx_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst), .en(en), .xlate(xlate), .en_load(en_load), .tbase(tbase),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .dec_below(dec_below), .dec_tnum(dec_tnum), .dec_idx(dec_idx),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_err(resp_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .idle(walker_idle)
  );
endmodule

// File: tb/pgchain_xlate_tb.sv
module pgchain_xlate_tb;
  localparam int AW = 40;
  localparam int NT = 4;
  localparam logic [AW-1:0] IB = 40'h30_0560_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          resp_valid, resp_err, mem_req;
  logic [AW-1:0] resp_addr, mem_addr;
  logic          mem_rvalid;
  logic [63:0]   mem_rdata;

  logic [63:0]   tmem [0:4095];
  logic          m_v;
  logic [AW-1:0] m_a;
  int            rd_count;
  int            n_run = 0, n_fail = 0;
  int            m_cur = 0;
  bit            m_xlate = 0;

  always #4 clk = ~clk;

  pgchain_xlate #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_addr(resp_addr), .resp_err(resp_err), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: two-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      m_v <= 1'b0; m_a <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0; rd_count <= 0;
    end else begin
      m_v <= mem_req;
      m_a <= mem_addr;
      mem_rvalid <= m_v;
      mem_rdata <= tmem[m_a[14:3]];
      if (mem_req) rd_count <= rd_count + 1;
    end
  end

  function automatic int slot_of(int t);
    case (t)
      0: return 3;
      1: return 0;
      2: return 6;
      3: return 2;
      default: return 7;
    endcase
  endfunction

  function automatic bit ent_ok(int t, int i);
    return ((t * 256 + i) % 37) != 5;
  endfunction

  function automatic logic [27:0] ent_page(int t, int i);
    int v;
    v = (t * 256 + i) * 7919 + 74565;
    return v[27:0];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [63:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_req(logic [AW-1:0] a, output logic [AW-1:0] ra,
                        output bit re, output int reads, output int lat);
    int rd0;
    int guard;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    rd0 = rd_count;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 2000) begin @(negedge clk); lat++; end
    ra = resp_addr; re = resp_err; reads = rd_count - rd0;
  endtask

  // reference model and check of one request
  task automatic xact(logic [AW-1:0] a, string req);
    logic [AW-1:0] ea, ra;
    bit ee, re;
    int er, reads, lat, t, i, c;
    logic [AW-1:0] off;
    ea = '0; ee = 1'b0; er = 0;
    if (!m_xlate) begin
      ea = a;
    end else if (a < IB) begin
      ee = 1'b1;
    end else begin
      off = a - IB;
      t = int'(off[AW-1:20]);
      i = int'(off[19:12]);
      c = m_cur;
      while (c != t && !ee) begin
        er++;
        if ((t > c && c >= NT - 1) || (t < c && c == 0)) ee = 1'b1;
        else c = (t > c) ? c + 1 : c - 1;
      end
      m_cur = c;
      if (!ee) begin
        er++;
        if (ent_ok(t, i)) ea = {ent_page(t, i), a[11:0]};
        else ee = 1'b1;
      end
    end
    do_req(a, ra, re, reads, lat);
    chk(lat < 2000, {req, " response arrives"}, 64'(lat), 64'd0);
    chk(re == ee, {req, " error flag"}, 64'(re), 64'(ee));
    chk(ra == ea, {req, " output address"}, 64'(ra), 64'(ea));
    chk(reads == er, {req, " table reads"}, 64'(reads), 64'(er));
    if (!m_xlate || (a < IB)) chk(lat == 1, {req, " one-cycle answer"}, 64'(lat), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int dummy;
    logic [AW-1:0] a;
    dummy = $urandom(32'h5EED);
    for (int k = 0; k < 4096; k++) tmem[k] = '0;
    for (int t = 0; t < NT; t++) begin
      for (int i = 0; i < 256; i++)
        tmem[slot_of(t) * 512 + i] = {24'h0, ent_page(t, i), 11'h0, ent_ok(t, i)};
      tmem[slot_of(t) * 512 + 510] = (t > 0) ?
        {24'h0, 28'(slot_of(t - 1)), 11'h0, 1'b1} : {24'h0, 28'h5, 11'h0, 1'b0};
      tmem[slot_of(t) * 512 + 511] = (t < NT - 1) ?
        {24'h0, 28'(slot_of(t + 1)), 11'h0, 1'b1} : {24'h0, 28'h1, 11'h0, 1'b0};
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    reg_read(3'd0, d); chk(d == 64'd0, "R10 enable clear after reset", d, 64'd0);
    reg_read(3'd1, d); chk(d == 64'd0, "R1 mode pass after reset", d, 64'd0);
    reg_read(3'd2, d); chk(d == 64'd1, "R10 ready after reset", d, 64'd1);
    @(negedge clk); chk(req_ready == 1'b0, "R11 no ready when disabled", 64'(req_ready), 64'd0);

    // R9 alignment
    reg_write(3'd3, 64'h3123);
    reg_read(3'd3, d); chk(d == 64'h3000, "R9 table base low bits", d, 64'h3000);
    reg_write(3'd4, 64'h30_0567_89AB);
    reg_read(3'd4, d); chk(d == 64'(IB), "R9 input base low bits", d, 64'(IB));

    // R1 pass-through
    reg_write(3'd1, 64'd0);
    reg_write(3'd0, 64'd1);
    m_xlate = 0;
    reg_read(3'd2, d); chk(d == 64'd0, "R10 not ready when enabled", d, 64'd0);
    xact(IB + 40'h4_0000, "R1");
    xact(IB - 40'h10, "R1");
    for (int k = 0; k < 5; k++) xact(40'({$urandom, $urandom}), "R1");

    // R8 writes ignored while enabled
    reg_write(3'd1, 64'd1);
    reg_read(3'd1, d); chk(d == 64'd0, "R8 mode locked", d, 64'd0);
    reg_write(3'd3, 64'h7000);
    reg_read(3'd3, d); chk(d == 64'h3000, "R8 table base locked", d, 64'h3000);
    reg_write(3'd4, 64'h0);
    reg_read(3'd4, d); chk(d == 64'(IB), "R8 input base locked", d, 64'(IB));
    xact(IB + 40'h123, "R8");

    // translate mode
    reg_write(3'd0, 64'd0);
    reg_read(3'd2, d); chk(d == 64'd1, "R10 ready after disable", d, 64'd1);
    reg_write(3'd1, 64'd1);
    reg_write(3'd0, 64'd1);
    m_xlate = 1; m_cur = 0;
    xact(IB + 40'h123, "R2");
    xact(IB + (40'd2 << 20) + (40'd5 << 12) + 40'hABC, "R4");
    xact(IB + 40'h7FF, "R4");
    xact(IB + (40'd5 << 12), "R3");
    xact(IB + (40'd4 << 20) + 40'h10, "R5");
    xact(IB + (40'd3 << 20) + (40'd9 << 12) + 40'h1, "R5");
    xact(IB - 40'd1, "R6");
    for (int k = 0; k < 120; k++) begin
      if ($urandom % 10 == 0) a = IB - 40'(1 + $urandom % 4096);
      else a = IB + 40'($urandom % (5 << 20));
      xact(a, "R2");
    end

    // R7 re-enable restarts at the table base
    xact(IB + (40'd3 << 20), "R7");
    reg_write(3'd0, 64'd0);
    reg_write(3'd0, 64'd1);
    m_cur = 0;
    xact(IB + (40'd1 << 20) + 40'h44, "R7");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule